// File: doc/BRIEF.md
# Prefixed Instruction Length Decoder

This block sits between an instruction byte fetch path and the execution logic of an 8-bit processor whose instruction set is widened by prefix bytes. It takes a stream of instruction bytes over a valid/ready handshake and splits them into complete instructions. For each instruction it returns one record that gives the byte count, the index override that is active, the opcode prefix that is active, the final opcode byte, an optional signed displacement and an optional 8-bit or 16-bit immediate value.

Bytes are not always in the same order. When an index override and the bit-operation prefix (0xCB) appear together, the displacement comes before the final opcode. In every other indexed form it comes after the opcode. Immediates always come last and are sent low byte first. An override byte that is cancelled by a later override, or by the extended prefix (0xED), is returned as a one-byte record marked as ignored. Decoding then starts again from the new byte, so no record is ever longer than four bytes.

The output is a single registered record slot. The decoder does not take a new byte while a record is waiting and the consumer is not accepting it. Execution and memory access are handled by other logic.

Top module: `pfx_instr_decoder`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Any byte other than 0xDD, 0xFD, 0xCB and 0xED that arrives first and needs no operand gives a record with len 1, idx 0, pfx 0, has_disp 0 and imm_n 0. Examples are 0x00, 0x76 and 0x80.
- R3: The root opcodes 00pp0001, 0x22, 0x2A, 0x32, 0x3A, 11ccc010, 0xC3, 11ccc100 and 0xCD take two immediate bytes, low byte first. The record has imm_n 2 and out_imm = {second byte, first byte}.
- R4: The root opcodes 00rrr110, 11aaa110, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38, 0xD3 and 0xDB take one immediate byte. The record has imm_n 1 and holds that byte in out_imm[7:0].
- R5: A leading 0xDD sets idx to 1 and a leading 0xFD sets idx to 2. Under an override, an opcode that uses the memory operand gets one displacement byte right after the opcode. The memory-operand opcodes are 01dddsss with ddd or sss equal to 110, 10aaa110, 0x34, 0x35 and 0x36. Other opcodes get no displacement.
- R6: Under an override, opcode 0x36 is followed by a displacement and then one immediate byte, for a total length of 4.
- R7: The 0xCB prefix sets pfx to 1. Without an override the record is 2 bytes. With an override, the byte after 0xCB is the displacement and the next byte is the opcode, for a total of 4 bytes.
- R8: The 0xED prefix sets pfx to 2. ED opcodes 01pp0011 and 01pp1011 take a 16-bit immediate, low byte first. All other ED opcodes take no operand.
- R9: An override byte followed by another override, or by 0xED, is emitted as a record with len 1, ignored 1, opcode equal to the override byte and idx of that override. Decoding then starts again from the new byte.
- R10: A record's len equals (idx≠0) + (pfx≠0) + 1 + has_disp + imm_n, and it is never greater than 4. An ignored record always has len 1. has_disp is set only when idx≠0.
- R11: While out_valid is high and out_ready is low, in_ready is low and every record field holds its value. Records come out in input order.
- R12: Under an override, HALT (0x76) gets no displacement. An opcode that combines an H/L register with the memory operand, such as 0x66, gets a displacement and reports the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction byte is offered |
| in_ready | output | 1 | The decoder takes the offered byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | A decoded record is held |
| out_ready | input | 1 | The consumer accepts the record |
| out_len | output | 3 | Instruction length in bytes (1 to 4) |
| out_idx | output | 2 | Override: 0 none, 1 IX, 2 IY |
| out_pfx | output | 2 | Prefix: 0 none, 1 CB, 2 ED |
| out_opcode | output | 8 | Final opcode byte (the override byte for an ignored record) |
| out_has_disp | output | 1 | A displacement byte is present |
| out_disp | output | 8 | Displacement byte |
| out_imm_n | output | 2 | Number of immediate bytes (0, 1 or 2) |
| out_imm | output | 16 | Immediate value, first byte in bits 7:0 |
| out_ignored | output | 1 | Record is a cancelled override |

## Verification
Some properties can be checked on every cycle. These are the length sum and its bound, the link between a displacement and an override, the shape of an ignored record, and the back-pressure rules for in_ready and for holding a record steady. The properties that depend on byte order can only be shown by the bench's directed sequences. These include where the displacement falls for indexed bit operations compared with other indexed forms, the low-byte-first order of immediates, which opcodes take operands, and how an override is cancelled and decoding restarted.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int BYTE_W  = 8;
  localparam int IMM_W   = 2 * BYTE_W;
  localparam int MAX_LEN = 4;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CNT_W   = 2;

  localparam logic [BYTE_W-1:0] CODE_IX = 8'hDD;
  localparam logic [BYTE_W-1:0] CODE_IY = 8'hFD;
  localparam logic [BYTE_W-1:0] CODE_CB = 8'hCB;
  localparam logic [BYTE_W-1:0] CODE_ED = 8'hED;

  typedef enum logic [1:0] {IDX_NONE = 2'd0, IDX_X = 2'd1, IDX_Y = 2'd2} idx_e;
  typedef enum logic [1:0] {PFX_NONE = 2'd0, PFX_CB = 2'd1, PFX_ED = 2'd2} pfx_e;

  typedef enum logic [2:0] {
    S_FIRST = 3'd0,
    S_IDX   = 3'd1,
    S_CB    = 3'd2,
    S_CBOP  = 3'd3,
    S_ED    = 3'd4,
    S_OPER  = 3'd5
  } st_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    idx_e              idx;
    pfx_e              pfx;
    logic [BYTE_W-1:0] opc;
    logic              has_disp;
    logic [BYTE_W-1:0] disp;
    logic [CNT_W-1:0]  imm_n;
    logic [IMM_W-1:0]  imm;
    logic              ignored;
  } rec_t;
endpackage

// File: rtl/pfx_opclass.sv
module pfx_opclass
  import pfx_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  input  logic              idx_on,
  input  logic              ed_ctx,
  output logic              need_disp,
  output logic [CNT_W-1:0]  imm_n
);
  logic uses_mem;
  logic imm16_root;
  logic imm8_root;
  logic imm16_ed;

  always_comb begin
    uses_mem = 1'b0;
    if (opc[7:6] == 2'b01)
      uses_mem = ((opc[5:3] == 3'b110) || (opc[2:0] == 3'b110)) && (opc != 8'h76);
    else if (opc[7:6] == 2'b10)
      uses_mem = (opc[2:0] == 3'b110);
    else if ((opc == 8'h34) || (opc == 8'h35) || (opc == 8'h36))
      uses_mem = 1'b1;

    imm16_root = ((opc[7:6] == 2'b00) && (opc[3:0] == 4'b0001)) ||
                 (opc == 8'h22) || (opc == 8'h2A) || (opc == 8'h32) || (opc == 8'h3A) ||
                 ((opc[7:6] == 2'b11) && (opc[2:0] == 3'b010)) ||
                 ((opc[7:6] == 2'b11) && (opc[2:0] == 3'b100)) ||
                 (opc == 8'hC3) || (opc == 8'hCD);

    imm8_root  = ((opc[7:6] == 2'b00) && (opc[2:0] == 3'b110)) ||
                 ((opc[7:6] == 2'b11) && (opc[2:0] == 3'b110)) ||
                 ((opc[7:5] == 3'b001) && (opc[2:0] == 3'b000)) ||
                 (opc == 8'h10) || (opc == 8'h18) || (opc == 8'hD3) || (opc == 8'hDB);

    imm16_ed   = (opc[7:6] == 2'b01) && (opc[2:0] == 3'b011);

    need_disp = idx_on && !ed_ctx && uses_mem;

    if (ed_ctx)
      imm_n = imm16_ed ? 2'd2 : 2'd0;
    else if (imm16_root)
      imm_n = 2'd2;
    else if (imm8_root)
      imm_n = 2'd1;
    else
      imm_n = 2'd0;
  end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
  import pfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output rec_t              rec_out,
  output logic              fire
);
  st_e              st, st_n;
  rec_t             acc, acc_n;
  logic             pend_disp, pend_n;
  logic [CNT_W-1:0] rem, rem_n;
  logic             imm_hi, hi_n;
  logic             opc_land;
  logic             cls_disp;
  logic [CNT_W-1:0] cls_imm;
  logic             is_ovr;

  pfx_opclass u_cls (
    .opc       (byte_in),
    .idx_on    (st == S_IDX),
    .ed_ctx    (st == S_ED),
    .need_disp (cls_disp),
    .imm_n     (cls_imm)
  );

  assign is_ovr = (byte_in == CODE_IX) || (byte_in == CODE_IY);

  always_comb begin
    st_n     = st;
    acc_n    = acc;
    pend_n   = pend_disp;
    rem_n    = rem;
    hi_n     = imm_hi;
    fire     = 1'b0;
    rec_out  = acc;
    opc_land = 1'b0;
    if (take) begin
      unique case (st)
        S_FIRST: begin
          acc_n     = '0;
          acc_n.len = LEN_W'(1);
          acc_n.opc = byte_in;
          if (is_ovr) begin
            acc_n.idx = (byte_in == CODE_IX) ? IDX_X : IDX_Y;
            st_n      = S_IDX;
          end else if (byte_in == CODE_CB) begin
            acc_n.pfx = PFX_CB;
            st_n      = S_CB;
          end else if (byte_in == CODE_ED) begin
            acc_n.pfx = PFX_ED;
            st_n      = S_ED;
          end else begin
            opc_land = 1'b1;
          end
        end
        S_IDX: begin
          if (is_ovr || (byte_in == CODE_ED)) begin
            fire            = 1'b1;
            rec_out         = acc;
            rec_out.ignored = 1'b1;
            acc_n           = '0;
            acc_n.len       = LEN_W'(1);
            acc_n.opc       = byte_in;
            if (byte_in == CODE_ED) begin
              acc_n.pfx = PFX_ED;
              st_n      = S_ED;
            end else begin
              acc_n.idx = (byte_in == CODE_IX) ? IDX_X : IDX_Y;
              st_n      = S_IDX;
            end
          end else if (byte_in == CODE_CB) begin
            acc_n.len = acc.len + LEN_W'(1);
            acc_n.pfx = PFX_CB;
            st_n      = S_CB;
          end else begin
            acc_n.len = acc.len + LEN_W'(1);
            acc_n.opc = byte_in;
            opc_land  = 1'b1;
          end
        end
        S_ED: begin
          acc_n.len = acc.len + LEN_W'(1);
          acc_n.opc = byte_in;
          opc_land  = 1'b1;
        end
        S_CB: begin
          acc_n.len = acc.len + LEN_W'(1);
          if (acc.idx != IDX_NONE) begin
            acc_n.disp     = byte_in;
            acc_n.has_disp = 1'b1;
            st_n           = S_CBOP;
          end else begin
            acc_n.opc = byte_in;
            fire      = 1'b1;
            rec_out   = acc_n;
            st_n      = S_FIRST;
          end
        end
        S_CBOP: begin
          acc_n.len = acc.len + LEN_W'(1);
          acc_n.opc = byte_in;
          fire      = 1'b1;
          rec_out   = acc_n;
          st_n      = S_FIRST;
        end
        S_OPER: begin
          acc_n.len = acc.len + LEN_W'(1);
          if (pend_disp) begin
            acc_n.disp = byte_in;
            pend_n     = 1'b0;
          end else if (!imm_hi) begin
            acc_n.imm[BYTE_W-1:0] = byte_in;
            hi_n                  = 1'b1;
          end else begin
            acc_n.imm[IMM_W-1:BYTE_W] = byte_in;
          end
          rem_n = rem - CNT_W'(1);
          if (rem == CNT_W'(1)) begin
            fire    = 1'b1;
            rec_out = acc_n;
            st_n    = S_FIRST;
          end
        end
        default: st_n = S_FIRST;
      endcase
      if (opc_land) begin
        acc_n.has_disp = cls_disp;
        acc_n.imm_n    = cls_imm;
        if (!cls_disp && (cls_imm == '0)) begin
          fire    = 1'b1;
          rec_out = acc_n;
          st_n    = S_FIRST;
        end else begin
          pend_n = cls_disp;
          rem_n  = {{(CNT_W-1){1'b0}}, cls_disp} + cls_imm;
          hi_n   = 1'b0;
          st_n   = S_OPER;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_FIRST;
      acc       <= '0;
      pend_disp <= 1'b0;
      rem       <= '0;
      imm_hi    <= 1'b0;
    end else begin
      st        <= st_n;
      acc       <= acc_n;
      pend_disp <= pend_n;
      rem       <= rem_n;
      imm_hi    <= hi_n;
    end
  end
endmodule

// File: rtl/pfx_outreg.sv
module pfx_outreg
  import pfx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  rec_t rec_in,
  input  logic pop,
  output rec_t rec_q,
  output logic vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= 1'b0;
      rec_q <= '0;
    end else if (load) begin
      vld   <= 1'b1;
      rec_q <= rec_in;
    end else if (pop) begin
      vld   <= 1'b0;
    end
  end
endmodule

// File: rtl/pfx_instr_decoder.sv
module pfx_instr_decoder
  import pfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic [1:0]        out_idx,
  output logic [1:0]        out_pfx,
  output logic [BYTE_W-1:0] out_opcode,
  output logic              out_has_disp,
  output logic [BYTE_W-1:0] out_disp,
  output logic [CNT_W-1:0]  out_imm_n,
  output logic [IMM_W-1:0]  out_imm,
  output logic              out_ignored
);
  logic take;
  logic fire;
  rec_t rec_new;
  rec_t rec_q;

  assign in_ready = !(out_valid && !out_ready);
  assign take     = in_valid && in_ready;

  pfx_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .byte_in (in_byte),
    .rec_out (rec_new),
    .fire    (fire)
  );

  pfx_outreg u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (fire),
    .rec_in (rec_new),
    .pop    (out_ready),
    .rec_q  (rec_q),
    .vld    (out_valid)
  );

  assign out_len      = rec_q.len;
  assign out_idx      = rec_q.idx;
  assign out_pfx      = rec_q.pfx;
  assign out_opcode   = rec_q.opc;
  assign out_has_disp = rec_q.has_disp;
  assign out_disp     = rec_q.disp;
  assign out_imm_n    = rec_q.imm_n;
  assign out_imm      = rec_q.imm;
  assign out_ignored  = rec_q.ignored;
endmodule

// File: rtl/pfx_instr_decoder_chk.sv
module pfx_instr_decoder_chk
  import pfx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LEN_W-1:0]  out_len,
  input logic [1:0]        out_idx,
  input logic [1:0]        out_pfx,
  input logic [BYTE_W-1:0] out_opcode,
  input logic              out_has_disp,
  input logic [BYTE_W-1:0] out_disp,
  input logic [CNT_W-1:0]  out_imm_n,
  input logic [IMM_W-1:0]  out_imm,
  input logic              out_ignored
);
  logic [LEN_W-1:0] len_sum;
  logic [LEN_W+2*2+2*BYTE_W+1+CNT_W+IMM_W+1-1:0] bundle;

  assign len_sum = {{(LEN_W-1){1'b0}}, (out_idx != 2'd0)} +
                   {{(LEN_W-1){1'b0}}, (out_pfx != 2'd0)} + LEN_W'(1) +
                   {{(LEN_W-1){1'b0}}, out_has_disp} +
                   {{(LEN_W-CNT_W){1'b0}}, out_imm_n};
  assign bundle = {out_len, out_idx, out_pfx, out_opcode, out_has_disp,
                   out_disp, out_imm_n, out_imm, out_ignored};

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(MAX_LEN))); // R10
  AST_LEN_SUM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ignored) |-> (out_len == len_sum)); // R10
  AST_DISP_NEEDS_IDX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_has_disp) |-> (out_idx != 2'd0)); // R10
  AST_IGNORED_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ignored) |-> (out_len == LEN_W'(1)) && (out_idx != 2'd0) && (out_pfx == 2'd0)); // R9
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R11
  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(bundle))); // R11
endmodule

bind pfx_instr_decoder pfx_instr_decoder_chk u_chk (.*);

// File: tb/pfx_instr_decoder_tb.sv
`timescale 1ns/1ps
module pfx_instr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_len;
  logic [1:0]  out_idx;
  logic [1:0]  out_pfx;
  logic [7:0]  out_opcode;
  logic        out_has_disp;
  logic [7:0]  out_disp;
  logic [1:0]  out_imm_n;
  logic [15:0] out_imm;
  logic        out_ignored;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pfx_instr_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_idx(out_idx),
    .out_pfx(out_pfx), .out_opcode(out_opcode), .out_has_disp(out_has_disp),
    .out_disp(out_disp), .out_imm_n(out_imm_n), .out_imm(out_imm), .out_ignored(out_ignored)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_byte  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_rec(input string tag, input int len, input int idx, input int pfx,
                            input logic [7:0] opc, input bit hd, input logic [7:0] disp,
                            input int imm_n, input logic [15:0] imm, input bit ign);
    int waited = 0;
    while (!out_valid && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check_eq({tag, " valid"}, 32'(out_valid), 32'd1);
    check_eq({tag, " R10 len"}, 32'(out_len), 32'(len));
    check_eq({tag, " idx"}, 32'(out_idx), 32'(idx));
    check_eq({tag, " pfx"}, 32'(out_pfx), 32'(pfx));
    check_eq({tag, " opcode"}, 32'(out_opcode), 32'(opc));
    check_eq({tag, " has_disp"}, 32'(out_has_disp), 32'(hd));
    check_eq({tag, " disp"}, 32'(out_disp), 32'(disp));
    check_eq({tag, " imm_n"}, 32'(out_imm_n), 32'(imm_n));
    check_eq({tag, " imm"}, 32'(out_imm), 32'(imm));
    check_eq({tag, " ignored"}, 32'(out_ignored), 32'(ign));
    pop();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1 out_valid", 32'(out_valid), 32'd0);
    check_eq("R1 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_root_single();
    send(8'h00); expect_rec("R2 nop", 1, 0, 0, 8'h00, 0, 8'h00, 0, 16'h0, 0);
    send(8'h76); expect_rec("R2 halt", 1, 0, 0, 8'h76, 0, 8'h00, 0, 16'h0, 0);
    send(8'h80); expect_rec("R2 alu", 1, 0, 0, 8'h80, 0, 8'h00, 0, 16'h0, 0);
  endtask

  task automatic t_imm16();
    send(8'h21); send(8'h34); send(8'h12);
    expect_rec("R3 ld rp", 3, 0, 0, 8'h21, 0, 8'h00, 2, 16'h1234, 0);
    send(8'hC3); send(8'h00); send(8'h80);
    expect_rec("R3 jp", 3, 0, 0, 8'hC3, 0, 8'h00, 2, 16'h8000, 0);
  endtask

  task automatic t_imm8();
    send(8'h3E); send(8'h5A);
    expect_rec("R4 ld r,n", 2, 0, 0, 8'h3E, 0, 8'h00, 1, 16'h005A, 0);
    send(8'h20); send(8'hFE);
    expect_rec("R4 jr cc", 2, 0, 0, 8'h20, 0, 8'h00, 1, 16'h00FE, 0);
  endtask

  task automatic t_index();
    send(8'hDD); send(8'h21); send(8'hCD); send(8'hAB);
    expect_rec("R5 ix imm16", 4, 1, 0, 8'h21, 0, 8'h00, 2, 16'hABCD, 0);
    send(8'hFD); send(8'h86); send(8'h05);
    expect_rec("R5 iy alu mem", 3, 2, 0, 8'h86, 1, 8'h05, 0, 16'h0, 0);
    send(8'hDD); send(8'h66); send(8'hF0);
    expect_rec("R12 h mem", 3, 1, 0, 8'h66, 1, 8'hF0, 0, 16'h0, 0);
    send(8'hDD); send(8'h76);
    expect_rec("R12 halt", 2, 1, 0, 8'h76, 0, 8'h00, 0, 16'h0, 0);
  endtask

  task automatic t_store_imm();
    send(8'hFD); send(8'h36); send(8'h80); send(8'h55);
    expect_rec("R6 st imm", 4, 2, 0, 8'h36, 1, 8'h80, 1, 16'h0055, 0);
  endtask

  task automatic t_cb();
    send(8'hCB); send(8'h11);
    expect_rec("R7 cb plain", 2, 0, 1, 8'h11, 0, 8'h00, 0, 16'h0, 0);
    send(8'hDD); send(8'hCB); send(8'h07); send(8'hC6);
    expect_rec("R7 cb indexed", 4, 1, 1, 8'hC6, 1, 8'h07, 0, 16'h0, 0);
  endtask

  task automatic t_ed();
    send(8'hED); send(8'h43); send(8'h78); send(8'h56);
    expect_rec("R8 ed store", 4, 0, 2, 8'h43, 0, 8'h00, 2, 16'h5678, 0);
    send(8'hED); send(8'h4B); send(8'h00); send(8'h90);
    expect_rec("R8 ed load", 4, 0, 2, 8'h4B, 0, 8'h00, 2, 16'h9000, 0);
    send(8'hED); send(8'hB0);
    expect_rec("R8 ed block", 2, 0, 2, 8'hB0, 0, 8'h00, 0, 16'h0, 0);
  endtask

  task automatic t_cancel();
    send(8'hDD); send(8'hFD);
    expect_rec("R9 dd then fd", 1, 1, 0, 8'hDD, 0, 8'h00, 0, 16'h0, 1);
    send(8'h21); send(8'h11); send(8'h22);
    expect_rec("R9 restart iy", 4, 2, 0, 8'h21, 0, 8'h00, 2, 16'h2211, 0);
    send(8'hFD); send(8'hED);
    expect_rec("R9 fd then ed", 1, 2, 0, 8'hFD, 0, 8'h00, 0, 16'h0, 1);
    send(8'h44);
    expect_rec("R9 restart ed", 2, 0, 2, 8'h44, 0, 8'h00, 0, 16'h0, 0);
  endtask

  task automatic t_backpressure();
    send(8'h07);
    repeat (3) @(negedge clk);
    check_eq("R11 valid held", 32'(out_valid), 32'd1);
    check_eq("R11 in_ready low", 32'(in_ready), 32'd0);
    check_eq("R11 opcode held", 32'(out_opcode), 32'h07);
    in_byte  = 8'h3C;
    in_valid = 1'b1;
    @(negedge clk);
    check_eq("R11 byte not taken", 32'(out_opcode), 32'h07);
    in_valid = 1'b0;
    expect_rec("R11 first", 1, 0, 0, 8'h07, 0, 8'h00, 0, 16'h0, 0);
    send(8'h3C);
    expect_rec("R11 second", 1, 0, 0, 8'h3C, 0, 8'h00, 0, 16'h0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_root_single();
    t_imm16();
    t_imm8();
    t_index();
    t_store_imm();
    t_cb();
    t_ed();
    t_cancel();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule